// File: doc/BRIEF.md
# Paged Monochrome Display Controller

This block holds the frame memory of a one-bit-per-pixel display, 128 columns by 64 rows by default, and takes updates through a few word-wide registers. The memory is split into horizontal pages, each eight rows tall. A page holds one byte per column, and bit `k` of a byte is row `8*page + k`. A processor first writes a magic word to a port-mode register. This decides whether bytes written to the shared data port are commands or pixel data.

In command mode, a page-select opcode moves the write pointer to the start of a page. In data mode, each byte is stored at the pointer and the column steps forward, wrapping inside the page. A separate instruction register can also select a page in any mode. A scan-out engine reads single pixels through a dedicated (x, y) port that never disturbs register traffic.

Top module: `mono_lcd_ctrl`

## Requirements
- R1: After reset, every pixel reads as 0, the port-mode register reads 0 (invalid mode), and page and column are 0.
- R2: Pixel (x, y) is bit `y % 8` of the byte at index `(y / 8) * COLS + x`. A data byte written with pointer (page, column) lands at index `page * COLS + column`.
- R3: A write of 0x00100011 to the port-mode register (offset 0x1AC) selects data mode, and 0x00104011 selects command mode. Any other value selects invalid mode.
- R4: In data mode, a write to the data port (offset 0x1C0) stores `wdata[7:0]` at the pointer. The column then increments, returning from COLS-1 to 0 without changing the page.
- R5: In command mode, a data-port byte of `0xB0 + p` with `p < PAGES` sets the page to `p` and the column to 0.
- R6: A write to the instruction register (offset 0x1BC) with byte `0xB0 + p`, `p < PAGES`, sets page `p` and column 0, whatever the port mode.
- R7: Command or instruction bytes outside the range `0xB0` to `0xB0 + PAGES - 1` leave page, column and memory unchanged.
- R8: Data-port writes in invalid mode change neither the memory nor the pointer.
- R9: Reads return data one cycle after `rd_en` and return 0 in any cycle not following `rd_en`. The port-mode register (0x1AC) and interrupt-control register (0x180) read back their last written words. Interrupt status (0x184) and all other offsets read as 0.
- R10: `pix_on` gives the pixel at (`pix_x`, `pix_y`) one cycle later. A data write in the same cycle as the read does not affect the value returned.
- R11: Only bits 7:0 of a data-port or instruction word are used. The upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (12) | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pix_x | input | X_W (7) | Pixel column for scan-out |
| pix_y | input | Y_W (6) | Pixel row for scan-out |
| pix_on | output | 1 | Lit state of the addressed pixel, one cycle later |

## Verification
The bench builds the controller with COLS = 16 and PAGES = 4. This makes the frame memory only 64 bytes and 512 pixels, so every pixel can be compared against a bench-side model after reset and again after the update sequence. With only four pages, the opcode 0xB5 lies inside the 0xB0–0xB7 pattern but outside the valid page range. This exercises the rejection path of R7 alongside a non-opcode byte. Column wraparound is also reached after just sixteen writes, so overwriting the start of a page is cheap to provoke.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam logic [31:0] MODE_DATA_MAGIC = 32'h0010_0011;
    localparam logic [31:0] MODE_CMD_MAGIC  = 32'h0010_4011;

    localparam logic [11:0] OFS_IRQ_CTL  = 12'h180;
    localparam logic [11:0] OFS_IRQ_STAT = 12'h184;
    localparam logic [11:0] OFS_MODE     = 12'h1AC;
    localparam logic [11:0] OFS_INSTR    = 12'h1BC;
    localparam logic [11:0] OFS_DATA     = 12'h1C0;

    // Upper five bits of every page-select opcode (0xB0 >> 3)
    localparam logic [4:0] PAGE_OP_HI = 5'h16;

    typedef enum logic [1:0] {
        PORT_OFF  = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CMD  = 2'd2
    } port_mode_e;

    function automatic port_mode_e decode_mode(input logic [31:0] word);
        if (word == MODE_DATA_MAGIC)     return PORT_DATA;
        else if (word == MODE_CMD_MAGIC) return PORT_CMD;
        else                             return PORT_OFF;
    endfunction

endpackage

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs #(
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic                                   rd_en,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [31:0]                            wdata,
    output logic [31:0]                            rdata,
    output logic                                   store_en,
    output logic [$clog2(COLS*PAGES)-1:0]          store_idx,
    output logic [7:0]                             store_byte,
    output logic [((PAGES > 1) ? $clog2(PAGES) : 1)-1:0] cur_page,
    output logic [$clog2(COLS)-1:0]                cur_col,
    output lcd_pkg::port_mode_e                    mode_kind
);
    import lcd_pkg::*;

    localparam int COL_W  = $clog2(COLS);
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int IDX_W  = $clog2(COLS * PAGES);

    typedef struct packed {
        logic [31:0]       mode;
        logic [31:0]       irq_ctl;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [31:0]       rdata;
    } regs_t;

    regs_t q, d;

    logic       hit_data, hit_instr, hit_mode, hit_irq;
    logic [7:0] in_byte;
    logic       is_page_op;
    logic       cmd_from_port;

    always_comb begin
        d          = q;
        d.rdata    = '0;
        in_byte    = wdata[7:0];
        mode_kind  = decode_mode(q.mode);
        hit_data   = wr_en && (addr == ADDR_W'(OFS_DATA));
        hit_instr  = wr_en && (addr == ADDR_W'(OFS_INSTR));
        hit_mode   = wr_en && (addr == ADDR_W'(OFS_MODE));
        hit_irq    = wr_en && (addr == ADDR_W'(OFS_IRQ_CTL));
        is_page_op = (in_byte[7:3] == PAGE_OP_HI) && (int'(in_byte[2:0]) < PAGES);
        cmd_from_port = hit_data && (mode_kind == PORT_CMD);

        store_en   = hit_data && (mode_kind == PORT_DATA);
        store_byte = in_byte;
        store_idx  = IDX_W'(q.page) * IDX_W'(COLS) + IDX_W'(q.col);

        if (store_en) begin
            d.col = (q.col == COL_W'(COLS - 1)) ? '0 : q.col + COL_W'(1);
        end

        if ((cmd_from_port || hit_instr) && is_page_op) begin
            d.page = in_byte[PAGE_W-1:0];
            d.col  = '0;
        end

        if (hit_mode) d.mode    = wdata;
        if (hit_irq)  d.irq_ctl = wdata;

        if (rd_en) begin
            if (addr == ADDR_W'(OFS_MODE))         d.rdata = q.mode;
            else if (addr == ADDR_W'(OFS_IRQ_CTL)) d.rdata = q.irq_ctl;
            else                                   d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata    = q.rdata;
    assign cur_page = q.page;
    assign cur_col  = q.col;

endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
    parameter int COLS  = 128,
    parameter int PAGES = 8
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              we,
    input  logic [$clog2(COLS*PAGES)-1:0]                     widx,
    input  logic [7:0]                                        wbyte,
    input  logic [$clog2(COLS)-1:0]                           rd_x,
    input  logic [((PAGES > 1) ? $clog2(PAGES) : 1)+2:0]      rd_y,
    output logic                                              pix_on
);
    localparam int NBYTES = COLS * PAGES;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int Y_W    = PAGE_W + 3;

    logic [7:0] mem_view [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_cell
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (we && (widx == IDX_W'(g))) cell_d = wbyte;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign mem_view[g] = cell_q;
    end

    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;
    logic             pix_d, pix_q;

    always_comb begin
        rd_idx  = IDX_W'(rd_y[Y_W-1:3]) * IDX_W'(COLS) + IDX_W'(rd_x);
        rd_byte = mem_view[rd_idx];
        pix_d   = rd_byte[rd_y[2:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= 1'b0;
        else        pix_q <= pix_d;
    end

    assign pix_on = pix_q;

endmodule

// File: rtl/mono_lcd_ctrl.sv
module mono_lcd_ctrl #(
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int ADDR_W = 12,
    localparam int X_W    = $clog2(COLS),
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int Y_W    = PAGE_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [X_W-1:0]    pix_x,
    input  logic [Y_W-1:0]    pix_y,
    output logic              pix_on
);
    localparam int IDX_W = $clog2(COLS * PAGES);

    logic                 store_en;
    logic [IDX_W-1:0]     store_idx;
    logic [7:0]           store_byte;
    logic [PAGE_W-1:0]    cur_page;
    logic [X_W-1:0]       cur_col;
    lcd_pkg::port_mode_e  mode_kind;

    lcd_ctrl_regs #(.COLS(COLS), .PAGES(PAGES), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .store_en   (store_en),
        .store_idx  (store_idx),
        .store_byte (store_byte),
        .cur_page   (cur_page),
        .cur_col    (cur_col),
        .mode_kind  (mode_kind)
    );

    lcd_vram #(.COLS(COLS), .PAGES(PAGES)) u_vram (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (store_en),
        .widx   (store_idx),
        .wbyte  (store_byte),
        .rd_x   (pix_x),
        .rd_y   (pix_y),
        .pix_on (pix_on)
    );

endmodule

// File: rtl/lcd_chk.sv
module lcd_chk #(
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int ADDR_W = 12,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         wdata,
    input logic [31:0]         rdata,
    input logic [PAGE_W-1:0]   cur_page,
    input logic [COL_W-1:0]    cur_col,
    input lcd_pkg::port_mode_e mode_kind
);
    import lcd_pkg::*;

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DATA) && mode_kind == PORT_DATA)
        |=> (($past(cur_col) == COL_W'(COLS - 1)) ? (cur_col == '0)
                                                  : (cur_col == $past(cur_col) + COL_W'(1))));

    // R6
    instr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_INSTR) && wdata[7:3] == PAGE_OP_HI
               && int'(wdata[2:0]) < PAGES)
        |=> (cur_page == $past(wdata[PAGE_W-1:0]) && cur_col == '0));

    // R8
    off_mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DATA) && mode_kind == PORT_OFF)
        |=> ($stable(cur_col) && $stable(cur_page)));

    // R3
    data_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MODE) && wdata == MODE_DATA_MAGIC)
        |=> (mode_kind == PORT_DATA));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    // R9
    irq_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_IRQ_STAT)) |=> (rdata == '0));

endmodule

bind mono_lcd_ctrl lcd_chk #(.COLS(COLS), .PAGES(PAGES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mono_lcd_ctrl.sv
module sim_mono_lcd_ctrl;
    localparam int COLS   = 16;
    localparam int PAGES  = 4;
    localparam int ADDR_W = 12;
    localparam int X_W    = 4;
    localparam int Y_W    = 5;
    localparam int NB     = COLS * PAGES;

    localparam logic [11:0] A_IRQC = 12'h180, A_IRQS = 12'h184, A_MODE = 12'h1AC,
                            A_INST = 12'h1BC, A_DATA = 12'h1C0;
    localparam logic [31:0] M_DATA = 32'h0010_0011, M_CMD = 32'h0010_4011;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [X_W-1:0] pix_x = '0;
    logic [Y_W-1:0] pix_y = '0;
    logic pix_on;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0]  exp_mem [NB];
    int          m_page = 0, m_col = 0;
    logic [31:0] m_mode = 0;

    always #10 clk = ~clk;

    mono_lcd_ctrl #(.COLS(COLS), .PAGES(PAGES), .ADDR_W(ADDR_W)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit page_op(input logic [7:0] b);
        return (b >= 8'hB0) && (b < 8'hB0 + PAGES);
    endfunction

    task automatic model(input logic [11:0] a, input logic [31:0] v);
        if (a == A_MODE) m_mode = v;
        else if (a == A_INST && page_op(v[7:0])) begin
            m_page = int'(v[7:0]) - 'hB0; m_col = 0;
        end else if (a == A_DATA) begin
            if (m_mode == M_DATA) begin
                exp_mem[m_page*COLS + m_col] = v[7:0];
                m_col = (m_col + 1) % COLS;
            end else if (m_mode == M_CMD && page_op(v[7:0])) begin
                m_page = int'(v[7:0]) - 'hB0; m_col = 0;
            end
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); wr_en = 1; addr = a; wdata = v;
        @(negedge clk); wr_en = 0;
        model(a, v);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); v = rdata; rd_en = 0;
    endtask

    function automatic logic exp_pix(input int x, input int y);
        logic [7:0] b;
        b = exp_mem[(y / 8) * COLS + x];
        return b[y % 8];
    endfunction

    task automatic sweep(input string req);
        for (int y = 0; y < PAGES*8; y++)
            for (int x = 0; x < COLS; x++) begin
                @(negedge clk); pix_x = X_W'(x); pix_y = Y_W'(y);
                @(negedge clk);
                chk(req, {31'd0, pix_on}, {31'd0, exp_pix(x, y)});
            end
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(A_MODE, v); chk("R1 mode after reset", v, 0);
        sweep("R1 blank memory");

        // R8: data write in invalid mode is dropped
        wr(A_DATA, 32'h0000_00FF);
        // R3: magic for data mode; R9: readback
        wr(A_MODE, M_DATA);
        rd(A_MODE, v); chk("R9 mode readback", v, M_DATA);
        @(negedge clk); chk("R9 idle rdata", rdata, 0);

        // R4: fill page 0 past its end to wrap
        for (int c = 0; c < COLS + 3; c++) wr(A_DATA, 32'(c * 11 + 5));

        // R5, R7: command mode page select and ignored bytes
        wr(A_MODE, M_CMD);
        wr(A_DATA, 32'h0000_00B2);
        wr(A_DATA, 32'h0000_00B5);
        wr(A_DATA, 32'h0000_0042);
        wr(A_MODE, M_DATA);
        for (int c = 0; c < 3; c++) wr(A_DATA, 32'(8'hC0 + c));

        // R6, R11: instruction register with garbage upper bits
        wr(A_INST, 32'hABCD_12B1);
        for (int c = 0; c < COLS; c++) wr(A_DATA, 32'h5A5A_0000 | 32'((c * 37) & 8'hFF));

        // R6 in invalid mode, R8 data ignored, R7 via instruction register
        wr(A_MODE, 32'h1234_5678);
        rd(A_MODE, v); chk("R9 invalid mode readback", v, 32'h1234_5678);
        wr(A_INST, 32'h0000_00B3);
        wr(A_DATA, 32'h0000_0077);
        wr(A_INST, 32'h0000_00A3);
        wr(A_MODE, M_DATA);
        for (int c = 0; c < COLS; c++) wr(A_DATA, 32'hFF00_0000 | 32'(8'h81 ^ c));

        // R11: command via data port with upper bits set
        wr(A_MODE, M_CMD);
        wr(A_DATA, 32'hFFFF_FFB0);
        wr(A_MODE, M_DATA);
        wr(A_DATA, 32'h0000_00E7);

        // R9: register reads
        wr(A_IRQC, 32'hDEAD_BEEF);
        rd(A_IRQC, v); chk("R9 irq ctl readback", v, 32'hDEAD_BEEF);
        rd(A_IRQS, v); chk("R9 irq status zero", v, 0);
        rd(12'h004, v); chk("R9 unknown offset zero", v, 0);
        rd(A_INST, v); chk("R9 write-only offset zero", v, 0);

        // R2, R4, R5, R6, R7, R8: full pixel comparison
        sweep("R2 pixel map");

        // R10: same-cycle write and pixel read of the pointer location
        begin
            int x0, y0;
            logic oldb, newb;
            x0 = m_col; y0 = m_page * 8 + 3;
            oldb = exp_pix(x0, y0);
            @(negedge clk);
            pix_x = X_W'(x0); pix_y = Y_W'(y0);
            wr_en = 1; addr = A_DATA; wdata = {24'd0, ~exp_mem[m_page*COLS + m_col]};
            @(negedge clk);
            wr_en = 0;
            chk("R10 read before write", {31'd0, pix_on}, {31'd0, oldb});
            model(A_DATA, wdata);
            newb = exp_pix(x0, y0);
            @(negedge clk);
            chk("R10 read after write", {31'd0, pix_on}, {31'd0, newb});
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule